// File: doc/BRIEF.md
# Interleaved TDM Packet Distributor

This block accepts a frame of time-division-multiplexed samples and hands it out as headed packets on two output streams. The streams feed a bank of 32 parallel filter channels. A frame is 4096 samples long. Samples arrive in channel-major order, so each channel owns a run of 128 consecutive samples. One packet is one header beat followed by the 128 samples of one channel.

Storage is a full-frame ping-pong buffer. One bank takes the incoming frame while the other is read out as packets. Each output stream serves half of the channels. It does not walk its channels in linear order: it alternates between the lower and upper group of eight, so that both downstream merge groups start receiving data at roughly the same time. The two streams are flow-controlled independently. The banks trade roles only when the write bank holds a whole frame and both streams have drained the read bank.

Top module: `tdm_pkt_distributor`

## Requirements
- R1: After reset, `in_ready` is high and both bits of `out_valid` are low.
- R2: The k-th sample accepted after a frame start (k counting from 0) is delivered as data beat k%128 of the packet for channel k/128.
- R3: An accepted sample with `in_sof` high is stored as sample 0 of the frame. Samples accepted before it in an unfinished frame never appear on the outputs.
- R4: Every packet begins with a single header beat whose bits [4:0] hold the channel number and whose upper bits are zero. Exactly 128 data beats follow the header.
- R5: `out_last` is high on the 128th data beat of each packet and low on every other beat, headers included.
- R6: Stream 0 sends the packets of one frame in channel order 0, 8, 1, 9, 2, 10, 3, 11, 4, 12, 5, 13, 6, 14, 7, 15.
- R7: Stream 1 sends the packets of one frame in channel order 16, 24, 17, 25, 18, 26, 19, 27, 20, 28, 21, 29, 22, 30, 23, 31.
- R8: While a stream has `out_valid` high and `out_ready` low, its valid, data and last are unchanged on the next cycle.
- R9: No packet appears before the first full frame has been written. Once a second frame fills the write bank while the read bank is still draining, `in_ready` stays low.
- R10: A stream that is held stalled does not stop the other stream from delivering all of its packets for the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with valid |
| in_sof | input | 1 | Marks the first sample of a frame |
| in_data | input | 16 | Input sample |
| out_valid | output | 2 | Per-stream beat valid |
| out_ready | input | 2 | Per-stream beat ready |
| out_last | output | 2 | Per-stream last data beat of a packet |
| out_data | output | 32 | Stream 0 in bits [15:0], stream 1 in bits [31:16] |

## Verification
The hardest state to reach is the one where a complete second frame sits in the write bank while the read bank is only partly drained. The stimulus holds both streams stalled while two frames are written, which reaches that state. It then opens only stream 0 for a long window, so that one stream finishes while the other has not started. A later frame is preceded by a partial run of samples without the frame marker. This shows that the marker discards that run. The last frames are driven under random backpressure on both streams.

// File: rtl/tdm_pkt_pkg.sv
package tdm_pkt_pkg;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_NUM_CH  = 32;
  localparam int DEF_CH_LEN  = 128;
  localparam int DEF_NUM_OUT = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2
  } pkt_phase_e;
endpackage

// File: rtl/tdm_sample_bank.sv
module tdm_sample_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tdm_frame_writer.sv
module tdm_frame_writer #(
  parameter int FRAME  = 4096,
  parameter int ADDR_W = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  output logic              in_ready,
  input  logic              clear,
  output logic              full,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0] cnt_q, cnt_d, base;
  logic              full_q, full_d;
  logic              accept;

  always_comb begin
    accept = in_valid && !full_q;
    base   = in_sof ? '0 : cnt_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    if (clear) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (accept) begin
      cnt_d  = base + ADDR_W'(1);
      full_d = (base == ADDR_W'(FRAME - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (clear || accept) begin
        cnt_q  <= cnt_d;
        full_q <= full_d;
      end
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign wr_en    = accept;
  assign wr_addr  = base;

  // R3: a marked sample restarts the frame count
  p_sof_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (cnt_q == ADDR_W'(1)));

  // R9: the last address of a frame closes the input until the swap
  p_fill_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(FRAME - 1)) |=> !in_ready);
endmodule

// File: rtl/tdm_pkt_reader.sv
module tdm_pkt_reader
  import tdm_pkt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LANE_CH = 16,
  parameter int CH_LEN  = 128,
  parameter int LANE    = 0,
  parameter int CH_W    = 5,
  localparam int LCH_W   = $clog2(LANE_CH),
  localparam int BEAT_W  = $clog2(CH_LEN),
  localparam int LADDR_W = LCH_W + BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               idle,
  output logic [LADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0]  rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_last,
  output logic [DATA_W-1:0]  out_data
);
  pkt_phase_e        phase_q, phase_d;
  logic [LCH_W-1:0]  pkt_q, pkt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [LCH_W-1:0]  local_ch;
  logic [CH_W-1:0]   chan_id;
  logic              step;

  // packet p alternates halves: even p -> lower group, odd p -> upper group
  assign local_ch = {pkt_q[0], pkt_q[LCH_W-1:1]};
  assign chan_id  = CH_W'(LANE * LANE_CH) + CH_W'(local_ch);
  assign step     = out_valid && out_ready;

  always_comb begin
    phase_d = phase_q;
    pkt_d   = pkt_q;
    beat_d  = beat_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_HDR;
          pkt_d   = '0;
        end
      end
      PH_HDR: begin
        if (step) begin
          phase_d = PH_DATA;
          beat_d  = '0;
        end
      end
      PH_DATA: begin
        if (step) begin
          if (beat_q == BEAT_W'(CH_LEN - 1)) begin
            if (pkt_q == LCH_W'(LANE_CH - 1)) begin
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_HDR;
              pkt_d   = pkt_q + LCH_W'(1);
            end
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pkt_q   <= '0;
      beat_q  <= '0;
    end else begin
      if (start || step) begin
        phase_q <= phase_d;
        pkt_q   <= pkt_d;
        beat_q  <= beat_d;
      end
    end
  end

  assign idle      = (phase_q == PH_IDLE);
  assign raddr     = {local_ch, beat_q};
  assign out_valid = (phase_q != PH_IDLE);
  assign out_last  = (phase_q == PH_DATA) && (beat_q == BEAT_W'(CH_LEN - 1));
  assign out_data  = (phase_q == PH_HDR) ? DATA_W'(chan_id) : rdata;

  // R8: a stalled beat is held unchanged
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R4: a finished packet other than the final one is followed by a header
  p_last_then_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && out_last && pkt_q != LCH_W'(LANE_CH - 1)) |=> (phase_q == PH_HDR));

  // R9: a new frame read-out only begins from idle
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == PH_IDLE));
endmodule

// File: rtl/tdm_pkt_distributor.sv
module tdm_pkt_distributor
  import tdm_pkt_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int CH_LEN  = DEF_CH_LEN,
  parameter int NUM_OUT = DEF_NUM_OUT,
  localparam int FRAME   = NUM_CH * CH_LEN,
  localparam int ADDR_W  = $clog2(FRAME),
  localparam int LANE_CH = NUM_CH / NUM_OUT,
  localparam int LDEPTH  = LANE_CH * CH_LEN,
  localparam int LADDR_W = $clog2(LDEPTH),
  localparam int LANE_W  = ADDR_W - LADDR_W,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sof,
  input  logic [DATA_W-1:0]         in_data,
  output logic [NUM_OUT-1:0]        out_valid,
  input  logic [NUM_OUT-1:0]        out_ready,
  output logic [NUM_OUT-1:0]        out_last,
  output logic [NUM_OUT*DATA_W-1:0] out_data
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic               wr_bank_q, wr_bank_d, rd_bank;
  logic               wr_full, wr_en, swap;
  logic [ADDR_W-1:0]  wr_addr;
  logic [NUM_OUT-1:0] rd_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  tdm_frame_writer #(.FRAME(FRAME), .ADDR_W(ADDR_W)) i_writer (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_sof(in_sof),
    .in_ready(in_ready), .clear(swap), .full(wr_full),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  always_comb begin
    swap      = wr_full && (&rd_idle);
    wr_bank_d = swap ? ~wr_bank_q : wr_bank_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_bank_q <= 1'b0;
    end else begin
      if (swap) begin
        wr_bank_q <= wr_bank_d;
      end
    end
  end
  assign rd_bank = ~wr_bank_q;

  for (genvar l = 0; l < NUM_OUT; l++) begin : g_lane
    logic [DATA_W-1:0]  bank_rdata [2];
    logic [LADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0]  lane_rdata;
    logic [DATA_W-1:0]  lane_data;
    logic               lane_hit;

    assign lane_hit = wr_en && (wr_addr[ADDR_W-1:LADDR_W] == LANE_W'(l));

    for (genvar b = 0; b < 2; b++) begin : g_bank
      tdm_sample_bank #(.W(DATA_W), .DEPTH(LDEPTH), .AW(LADDR_W)) i_bank (
        .clk(clk),
        .we(lane_hit && (wr_bank_q == 1'(b))),
        .waddr(wr_addr[LADDR_W-1:0]),
        .wdata(in_data),
        .raddr(rd_addr),
        .rdata(bank_rdata[b])
      );
    end

    assign lane_rdata = rd_bank ? bank_rdata[1] : bank_rdata[0];

    tdm_pkt_reader #(
      .DATA_W(DATA_W), .LANE_CH(LANE_CH), .CH_LEN(CH_LEN),
      .LANE(l), .CH_W(CH_W)
    ) i_reader (
      .clk(clk), .rst_n(rst_n_s), .start(swap), .idle(rd_idle[l]),
      .raddr(rd_addr), .rdata(lane_rdata),
      .out_valid(out_valid[l]), .out_ready(out_ready[l]),
      .out_last(out_last[l]), .out_data(lane_data)
    );

    assign out_data[l*DATA_W +: DATA_W] = lane_data;
  end

  // R9: a full write bank with a stream still draining blocks input
  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_full && !(&rd_idle)) |=> !in_ready);

  // R9: the banks only trade roles after all streams went idle
  p_swap_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $changed(wr_bank_q) |-> $past(&rd_idle));
endmodule

// File: tb/test_tdm_pkt_distributor.sv
module test_tdm_pkt_distributor;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        in_sof;
  logic [15:0] in_data;
  logic [1:0]  out_valid;
  logic [1:0]  out_ready;
  logic [1:0]  out_last;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 0;

  // expected beats: {is_header, last, data}
  logic [17:0] q0[$];
  logic [17:0] q1[$];

  int          mode     = 1;   // 0: random 50%, 1: all stalled, 2: lane0 only, 3: random 75%
  bit          mon_en   = 0;
  bit          first_in = 0;
  int          hs0 = 0, hs1 = 0;
  bit [1:0]    held;
  logic [15:0] held_data [2];
  logic        held_last [2];
  string       data_tag = "R2";

  tdm_pkt_distributor i_tdm_pkt_distributor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sval(input int f, input int n);
    return {f[3:0], n[11:0]};
  endfunction

  task automatic push_frame(input int f);
    for (int l = 0; l < 2; l++) begin
      for (int p = 0; p < 16; p++) begin
        int ch;
        ch = l * 16 + (p % 2) * 8 + p / 2;
        if (l == 0) q0.push_back({1'b1, 1'b0, 16'(ch)});
        else        q1.push_back({1'b1, 1'b0, 16'(ch)});
        for (int k = 0; k < 128; k++) begin
          logic [17:0] e;
          e = {1'b0, (k == 127), sval(f, ch * 128 + k)};
          if (l == 0) q0.push_back(e);
          else        q1.push_back(e);
        end
      end
    end
  endtask

  task automatic send_sample(input logic [15:0] d, input logic sof);
    if ($urandom_range(3) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = sof;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input int f, input int junk);
    for (int j = 0; j < junk; j++) send_sample({4'hF, 12'(j)}, 1'b0);
    for (int n = 0; n < 4096; n++) send_sample(sval(f, n), (n == 0));
    push_frame(f);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic check_beat(input int l, input logic [15:0] d, input logic last);
    logic [17:0] e;
    int          empty;
    empty = (l == 0) ? (q0.size() == 0) : (q1.size() == 0);
    if (empty != 0) begin
      chk(1'b0, (l == 0) ? "R6" : "R7", "unexpected beat", d, 0);
      return;
    end
    e = (l == 0) ? q0.pop_front() : q1.pop_front();
    if (e[17]) chk(d == e[15:0], (l == 0) ? "R4 R6" : "R4 R7", "header", d, e[15:0]);
    else       chk(d == e[15:0], data_tag, "payload", d, e[15:0]);
    chk(last == e[16], "R5", "last flag", last, e[16]);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      case (mode)
        0: out_ready = 2'($urandom_range(3));
        1: out_ready = 2'b00;
        2: out_ready = 2'b01;
        default: out_ready = {($urandom_range(3) != 0), ($urandom_range(3) != 0)};
      endcase
      #1;
      if (!first_in) chk(out_valid == 2'b00, "R9", "output before first frame", out_valid, 0);
      for (int l = 0; l < 2; l++) begin
        if (held[l]) begin
          chk(out_valid[l] && out_data[l*16 +: 16] == held_data[l] && out_last[l] == held_last[l],
              "R8", "held beat changed", out_data[l*16 +: 16], held_data[l]);
        end
        if (out_valid[l] && out_ready[l]) begin
          check_beat(l, out_data[l*16 +: 16], out_last[l]);
          if (l == 0) hs0++;
          else        hs1++;
        end
        held[l]      = out_valid[l] && !out_ready[l];
        held_data[l] = out_data[l*16 +: 16];
        held_last[l] = out_last[l];
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sof    = 1'b0;
    in_data   = '0;
    out_ready = 2'b00;
    held      = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 2'b00, "R1", "out_valid after reset", out_valid, 0);
    mon_en = 1;

    // two frames while both streams are stalled
    mode = 1;
    send_frame(1, 0);
    first_in = 1;
    send_frame(2, 0);
    repeat (20) @(negedge clk);
    #2;
    chk(in_ready == 1'b0, "R9", "input open with both banks busy", in_ready, 0);
    chk(out_valid == 2'b11, "R9", "both streams presenting", out_valid, 3);

    // only stream 0 may move
    hs0  = 0;
    hs1  = 0;
    mode = 2;
    repeat (3000) @(negedge clk);
    #2;
    chk(hs0 == 2064, "R10", "stream 0 beats with stream 1 stalled", hs0, 2064);
    chk(hs1 == 0, "R10", "stream 1 beats while stalled", hs1, 0);
    chk(in_ready == 1'b0, "R9", "input open before stream 1 drained", in_ready, 0);

    // random backpressure, partial run then frame marker
    mode = 0;
    send_frame(3, 100);
    data_tag = "R3";
    mode = 3;
    send_frame(4, 0);

    while ((q0.size() != 0 || q1.size() != 0)) @(negedge clk);
    repeat (300) @(negedge clk);
    #2;
    chk(q0.size() == 0, "R6", "stream 0 beats left", q0.size(), 0);
    chk(q1.size() == 0, "R7", "stream 1 beats left", q1.size(), 0);
    chk(out_valid == 2'b00, "R6", "streams idle after all frames", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "input open after drain", in_ready, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule